// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a watchdog timer that sits on a register bus. A 32-bit counter counts up on a slow time base of 32.768 kHz, optionally slowed by a power-of-two prescaler. When the counter passes its all-ones value it raises a reset request and reloads itself. Software arms or disarms the timer by writing a pair of key words to a key register, one after the other. Firmware keeps the system alive by writing the trigger register with a value different from the last one. Each such write copies the load register into the counter.

Register writes are posted. A write arrives in the fast bus clock and takes effect on the next slow tick, which is a one-cycle enable pulse `tick_en` in the same clock. While a write is in flight, its pending flag in the status register is set. Software polls that flag before it writes the same register again. The bus side is plain: a write strobe that is never back-pressured and a combinational read mux. Flow control is the pending flag. A write to a register whose flag is set is dropped.

For a timeout of T seconds with the prescaler off, the load value is 2^32 − T·32768. After reset the load value gives a 60 s timeout (0xFFE20000). The supported timeouts run from 1 s up to one day.

Top module: `wdt_keyseq`

## Requirements
- R1: After reset the timer is stopped and all pending flags are clear. The counter and load register hold 0xFFE20000, and the control and trigger registers read 0. `rst_req` is low.
- R2: Word addresses are 0 control, 1 load, 2 trigger, 3 key, 4 status (read only) and 5 counter (read only). An accepted write to addresses 0–3 sets its status bit: control bit 0, load bit 2, trigger bit 3, key bit 4. The write takes effect at the next `tick_en`, and the flag clears in that same cycle.
- R3: A write to a register whose pending flag is set is dropped. The staged value and the value later applied are unchanged by it.
- R4: The timer starts only when key word 0xBBBB is applied and then key word 0x4444 is applied next.
- R5: The timer stops only when key word 0xAAAA is applied and then key word 0x5555 is applied next.
- R6: If any other word follows a first key word, the sequence returns to idle and the run state does not change. A second key word that arrives on its own does nothing.
- R7: While running, the counter adds one on each `tick_en`. When control bit 5 is set, it adds one every 2^P ticks instead, where P is control bits 4:2.
- R8: An applied trigger value that differs from the stored trigger value copies the load register into the counter and restarts the prescale phase. An applied value equal to the stored one has no effect.
- R9: Applying a load write leaves the counter untouched. The new value is used at the next trigger reload or overflow.
- R10: When a counting step finds the counter at all-ones, the counter takes the load value and `rst_req` goes high. `rst_req` stays high until the next `tick_en` (one slow period).
- R11: While stopped, the counter holds its value on every tick, apart from trigger reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse per slow-clock period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read word address |
| rd_data | output | 32 | Read data, combinational |
| rst_req | output | 1 | Reset request, high for one slow period per overflow |

## Verification
The assertions assume that `tick_en` is a single-cycle pulse and that software polls a register's pending flag before writing that register again. The one exception is the deliberate back-to-back write that exercises R3. The stimulus produces a tick every fourth clock and issues every write through a task that polls the matching status bit before and after the strobe, so each posted write is applied before the next one is sent.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 3;
  localparam int N_POST = 4;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_LOAD = 3'd1;
  localparam logic [ADDR_W-1:0] A_TRIG = 3'd2;
  localparam logic [ADDR_W-1:0] A_KEY  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd5;
  localparam int SLOT_CTRL = 0;
  localparam int SLOT_LOAD = 1;
  localparam int SLOT_TRIG = 2;
  localparam int SLOT_KEY  = 3;
  localparam int PTV_LSB   = 2;
  localparam logic [15:0] KEY_ON1  = 16'hBBBB;
  localparam logic [15:0] KEY_ON2  = 16'h4444;
  localparam logic [15:0] KEY_OFF1 = 16'hAAAA;
  localparam logic [15:0] KEY_OFF2 = 16'h5555;

  typedef enum logic [1:0] {KS_IDLE, KS_ARM_ON, KS_ARM_OFF} key_state_e;

  // status bit position for each posted slot
  function automatic int stat_bit(input int slot);
    case (slot)
      0:       return 0;
      1:       return 2;
      2:       return 3;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/wdt_post_slot.sv
module wdt_post_slot #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          wr_hit,
  input  logic [DW-1:0] wr_data,
  output logic          pend,
  output logic          apply,
  output logic [DW-1:0] stage
);
  logic          pend_q;
  logic [DW-1:0] stage_q;
  logic          accept;

  assign accept = wr_hit && !pend_q;
  assign apply  = pend_q && tick_en;
  assign pend   = pend_q;
  assign stage  = stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      stage_q <= '0;
    end else begin
      if (apply) pend_q <= 1'b0;
      if (accept) begin
        pend_q  <= 1'b1;
        stage_q <= wr_data;
      end
    end
  end

  // R3
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> $stable(stage_q));
  // R2
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !tick_en) |=> pend_q);
endmodule

// File: rtl/wdt_key_fsm.sv
module wdt_key_fsm
  import wdt_pkg::*;
#(
  parameter int KEY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             apply,
  input  logic [KEY_W-1:0] word,
  output logic             run
);
  key_state_e st_q, st_d;
  logic       run_q, run_d;

  always_comb begin
    st_d  = st_q;
    run_d = run_q;
    if (apply) begin
      st_d = KS_IDLE;
      case (st_q)
        KS_IDLE: begin
          if (word == KEY_W'(KEY_ON1))       st_d = KS_ARM_ON;
          else if (word == KEY_W'(KEY_OFF1)) st_d = KS_ARM_OFF;
        end
        KS_ARM_ON:  if (word == KEY_W'(KEY_ON2))  run_d = 1'b1;
        KS_ARM_OFF: if (word == KEY_W'(KEY_OFF2)) run_d = 1'b0;
        default: st_d = KS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= KS_IDLE;
      run_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      run_q <= run_d;
    end
  end

  assign run = run_q;

  // R4
  start_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> ($past(apply) && $past(word) == KEY_W'(KEY_ON2)));
  // R5
  stop_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> ($past(apply) && $past(word) == KEY_W'(KEY_OFF2)));
  // R6
  lone_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && st_q == KS_IDLE) |=> $stable(run_q));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int            CW       = 32,
  parameter int            PW       = 3,
  parameter logic [CW-1:0] RST_LOAD = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          run,
  input  logic          pre_en,
  input  logic [PW-1:0] ptv,
  input  logic          reload,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] count,
  output logic          rst_req
);
  localparam int DIV_W = (1 << PW) - 1;

  logic [CW-1:0]    cnt_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;
  logic             step, ovf, rst_q;

  assign mask = DIV_W'((1 << ptv) - 1);
  assign step = !pre_en || (div_q == mask);
  assign ovf  = tick_en && run && step && !reload && (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RST_LOAD;
      div_q <= '0;
      rst_q <= 1'b0;
    end else if (tick_en) begin
      rst_q <= ovf;
      if (reload) begin
        cnt_q <= load_val;
        div_q <= '0;
      end else if (run) begin
        div_q <= step ? '0 : div_q + 1'b1;
        if (step) cnt_q <= (&cnt_q) ? load_val : cnt_q + 1'b1;
      end else begin
        div_q <= '0;
      end
    end
  end

  assign count   = cnt_q;
  assign rst_req = rst_q;

  // R7
  count_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_q));
  // R11
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !run && !reload) |=> $stable(cnt_q));
  // R10
  req_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_q && !tick_en) |=> rst_q);
  // R10
  req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> ($past(run) && cnt_q == $past(load_val)));
endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
  import wdt_pkg::*;
#(
  parameter int DW      = 32,
  parameter int CW      = 32,
  parameter int PTV_W   = 3,
  parameter int KEY_W   = 16,
  parameter int SLOW_HZ = 32768,
  parameter int TMO_S   = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              rst_req
);
  localparam longint unsigned SPAN = longint'(TMO_S) * longint'(SLOW_HZ);
  localparam logic [CW-1:0] RST_LOAD = CW'((64'd1 << CW) - SPAN);
  localparam int PRE_BIT = PTV_LSB + PTV_W;

  logic [N_POST-1:0] pend, apply;
  logic [DW-1:0]     stage [N_POST];

  for (genvar i = 0; i < N_POST; i++) begin : g_post
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(i));
    wdt_post_slot #(.DW(DW)) u_slot (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .wr_hit(hit), .wr_data(wr_data),
      .pend(pend[i]), .apply(apply[i]), .stage(stage[i])
    );
  end

  logic             pre_q;
  logic [PTV_W-1:0] ptv_q;
  logic [CW-1:0]    load_q;
  logic [DW-1:0]    trig_q;
  logic             trig_new, run;
  logic [CW-1:0]    cnt;

  assign trig_new = apply[SLOT_TRIG] && (stage[SLOT_TRIG] != trig_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= 1'b0;
      ptv_q  <= '0;
      load_q <= RST_LOAD;
      trig_q <= '0;
    end else begin
      if (apply[SLOT_CTRL]) begin
        pre_q <= stage[SLOT_CTRL][PRE_BIT];
        ptv_q <= stage[SLOT_CTRL][PTV_LSB +: PTV_W];
      end
      if (apply[SLOT_LOAD]) load_q <= stage[SLOT_LOAD][CW-1:0];
      if (trig_new)         trig_q <= stage[SLOT_TRIG];
    end
  end

  wdt_key_fsm #(.KEY_W(KEY_W)) u_keys (
    .clk(clk), .rst_n(rst_n), .apply(apply[SLOT_KEY]),
    .word(stage[SLOT_KEY][KEY_W-1:0]), .run(run)
  );

  wdt_counter #(.CW(CW), .PW(PTV_W), .RST_LOAD(RST_LOAD)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(run),
    .pre_en(pre_q), .ptv(ptv_q), .reload(trig_new), .load_val(load_q),
    .count(cnt), .rst_req(rst_req)
  );

  logic [DW-1:0] status;
  always_comb begin
    status = '0;
    for (int i = 0; i < N_POST; i++) status[stat_bit(i)] = pend[i];
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = DW'({pre_q, ptv_q}) << PTV_LSB;
      A_LOAD:  rd_data = DW'(load_q);
      A_TRIG:  rd_data = trig_q;
      A_STAT:  rd_data = status;
      A_CNT:   rd_data = DW'(cnt);
      default: rd_data = '0;
    endcase
  end

  // R8
  same_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply[SLOT_TRIG] && !trig_new && !run) |=> $stable(cnt));
  // R9
  load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply[SLOT_LOAD] && !trig_new && !run) |=> $stable(cnt));
endmodule

// File: tb/wdt_keyseq_tb_top.sv
module wdt_keyseq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = 3'd5;
  logic [31:0] rd_data;
  logic        rst_req;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int tdiv = 0;

  always #5 clk = ~clk;

  wdt_keyseq dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .rst_req(rst_req)
  );

  // tick every fourth clock
  always @(negedge clk) begin
    tick_en = (tdiv % 4 == 3);
    tdiv++;
  end

  // behavioural reference model
  bit          m_run, m_pre, m_rst;
  int          m_ptv, m_div, m_ks;
  bit [31:0]   m_cnt, m_load, m_trig;
  bit [3:0]    m_pend;
  bit [31:0]   m_stage [4];

  function automatic bit [31:0] m_read(input bit [2:0] a);
    case (a)
      0: return (32'(m_pre) << 5) | (32'(m_ptv) << 2);
      1: return m_load;
      2: return m_trig;
      4: return {27'd0, m_pend[3], m_pend[2], m_pend[1], 1'b0, m_pend[0]};
      5: return m_cnt;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_pre = 0; m_rst = 0; m_ptv = 0; m_div = 0; m_ks = 0;
      m_cnt = 32'hFFE20000; m_load = 32'hFFE20000; m_trig = 0; m_pend = 0;
    end else begin
      bit acc; bit [3:0] op; bit [31:0] ol; bit orun; bit reload; bit step;
      op = m_pend; ol = m_load; orun = m_run;
      acc = wr_en && wr_addr < 4 && !op[wr_addr[1:0]];
      if (tick_en) begin
        reload = op[2] && (m_stage[2] != m_trig);
        step = !m_pre || (m_div == (1 << m_ptv) - 1);
        m_rst = 0;
        if (reload) begin m_cnt = ol; m_div = 0; end
        else if (orun) begin
          m_div = step ? 0 : m_div + 1;
          if (step) begin
            if (m_cnt == 32'hFFFFFFFF) begin m_cnt = ol; m_rst = 1; end
            else m_cnt = m_cnt + 1;
          end
        end else m_div = 0;
        if (op[0]) begin m_pre = m_stage[0][5]; m_ptv = int'(m_stage[0][4:2]); end
        if (op[1]) m_load = m_stage[1];
        if (reload) m_trig = m_stage[2];
        if (op[3]) begin
          bit [15:0] w; w = m_stage[3][15:0];
          case (m_ks)
            0: m_ks = (w == 16'hBBBB) ? 1 : (w == 16'hAAAA) ? 2 : 0;
            1: begin if (w == 16'h4444) m_run = 1; m_ks = 0; end
            default: begin if (w == 16'h5555) m_run = 0; m_ks = 0; end
          endcase
        end
        m_pend = 0;
      end
      if (acc) begin
        m_pend[wr_addr[1:0]] = 1;
        m_stage[wr_addr[1:0]] = wr_data;
      end
    end
  end

  // cycle compare, sampled after the edge
  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      total++;
      if (rd_data !== m_read(rd_addr) || rst_req !== m_rst) begin
        bad++;
        $display("FAIL R2/R7/R10 model cycle %0d addr %0d: rd=%h exp=%h req=%b exp=%b",
                 cyc, rd_addr, rd_data, m_read(rd_addr), rst_req, m_rst);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: expired, actual=%0d expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input bit [31:0] act, input bit [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int sbit(input bit [2:0] a);
    case (a) 0: return 0; 1: return 2; 2: return 3; default: return 4; endcase
  endfunction

  task automatic rd(input bit [2:0] a, output bit [31:0] v);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic wait_clear(input bit [2:0] a);
    bit [31:0] s;
    do rd(3'd4, s); while (s[sbit(a)]);
  endtask

  task automatic strobe(input bit [2:0] a, input bit [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wr(input bit [2:0] a, input bit [31:0] d);
    wait_clear(a);
    strobe(a, d);
    wait_clear(a);
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  initial begin
    bit [31:0] v, c0, c1;
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(3'd5, v); chk("R1 count", v, 32'hFFE20000);
    rd(3'd4, v); chk("R1 status", v, 0);
    rd(3'd1, v); chk("R1 load", v, 32'hFFE20000);
    chk("R1 rst_req", 32'(rst_req), 0);
    // R2 posted write flag
    wait_clear(3'd1);
    strobe(3'd1, 32'hFFFFFF00);
    rd(3'd4, v); chk("R2 load pending bit", v & 32'h1D, 32'h4);
    wait_clear(3'd1);
    rd(3'd1, v); chk("R2 load applied", v, 32'hFFFFFF00);
    // R3 second write while pending dropped
    wait_clear(3'd0);
    strobe(3'd0, 32'h20);
    strobe(3'd0, 32'h0C);
    wait_clear(3'd0);
    rd(3'd0, v); chk("R3 ctrl keeps first", v, 32'h20);
    wr(3'd0, 32'h0);
    // R8 trigger reload
    wr(3'd2, 32'h1234);
    rd(3'd5, v); chk("R8 trigger reload", v, 32'hFFFFFF00);
    // R4 start
    wr(3'd3, 32'hBBBB); wr(3'd3, 32'h4444);
    rd(3'd5, c0); wait_ticks(10); rd(3'd5, c1);
    chk("R4 running after start", 32'(c1 > c0), 1);
    // R6 broken stop sequence
    wr(3'd3, 32'hAAAA); wr(3'd3, 32'h1234); wr(3'd3, 32'h5555);
    rd(3'd5, c0); wait_ticks(8); rd(3'd5, c1);
    chk("R6 still running", 32'(c1 > c0), 1);
    // R9 load write leaves counter
    wr(3'd1, 32'hFFFFFFF0);
    rd(3'd5, v); chk("R9 count not reloaded", 32'(v == 32'hFFFFFFF0), 0);
    // R10 overflow
    rd_addr = 3'd5;
    while (!rst_req) @(negedge clk);
    chk("R10 reload on overflow", rd_data, 32'hFFFFFFF0);
    hi = 0;
    while (rst_req) begin hi++; @(negedge clk); end
    chk("R10 request width", 32'(hi), 4);
    // R7 prescaler 2^2
    wr(3'd0, 32'h28);
    wait_ticks(40);
    rd(3'd0, v); chk("R7 ctrl readback", v, 32'h28);
    // R5 stop
    wr(3'd3, 32'hAAAA); wr(3'd3, 32'h5555);
    rd(3'd5, c0); wait_ticks(20); rd(3'd5, c1);
    chk("R11 holds when stopped", c1, c0);
    // R8 same trigger value ignored
    wr(3'd2, 32'h1234);
    rd(3'd5, v); chk("R8 same value no reload", v, c0);
    wr(3'd2, 32'hEDCB);
    rd(3'd5, v); chk("R8 new value reloads", v, 32'hFFFFFFF0);
    // R6 lone or repeated first key does not start
    wr(3'd3, 32'hBBBB); wr(3'd3, 32'hBBBB); wr(3'd3, 32'h4444);
    rd(3'd5, c0); wait_ticks(12); rd(3'd5, c1);
    chk("R6 no start", c1, c0);
    // R4 proper start after that
    wr(3'd3, 32'hBBBB); wr(3'd3, 32'h4444);
    wait_ticks(30);
    rd(3'd5, v); chk("R4 restarted", 32'(v != c0), 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule